// File: doc/BRIEF.md
# Dual Wiper Position Controller with Serial Command Port

This block receives commands over a write-only three-wire serial link (active-low select, serial clock, serial data) and keeps two 8-bit wiper position registers, A and B. Each wiper has a retained shadow register beside it. The two parallel wiper codes, from 0 to 255, drive an external tap selector. Commands can set a wiper, set a shadow register, save wipers into shadows, or restore shadows into wipers. One address code acts on both channels at once for the save and restore commands.

All three serial pins pass through a synchroniser into the system clock domain, and edges are detected there. Every bit is captured according to its position in the frame. A frame is acted on only when the select line returns high. Write frames must carry exactly 16 bits. Save and restore frames may carry 8 bits, or 16 bits with the last eight ignored. A busy flag stays high for a fixed number of cycles after any shadow update, and a frame that begins while it is high is ignored. After reset, each wiper is loaded from its shadow register.

The controller is a five-state machine:
- RECALL copies the shadows into the wipers and then goes to IDLE.
- IDLE goes to SHIFT when the select line falls.
- SHIFT captures bits and goes to COMMIT when the select line rises.
- COMMIT applies a valid action. It goes to BUSY if a shadow register changed, and to IDLE otherwise.
- BUSY counts down and returns to IDLE when the count reaches zero.

Top module: `dual_wiper_ctrl`

## Requirements
- R1: While select is low, each rising edge of the serial clock, seen after synchronisation, captures one data bit. An edge in any other state is ignored.
- R2: Bits are numbered by clock order, starting at 1. Clocks 3 and 4 carry command bits 1 and 0. Clocks 7 and 8 carry address bits 1 and 0. Clocks 9 to 16 carry data bits 7 down to 0. Clocks 1, 2, 5 and 6 are ignored.
- R3: Command 00 loads the data byte into the wiper of the selected channel.
- R4: Command 01 loads the data byte into the shadow register of the selected channel. The wipers do not change.
- R5: Command 10 copies the wiper into the shadow register. Command 11 copies the shadow register into the wiper.
- R6: Address 01 selects channel A and address 10 selects channel B. Address 11 selects both channels, but only for commands 10 and 11. Address 00 has no effect with any command, and address 11 has no effect with commands 00 and 01.
- R7: A frame of exactly 16 clocks is accepted for any command. A frame of exactly 8 clocks is accepted only for commands 10 and 11. Any other count, including more than 16, is discarded and no register changes.
- R8: No register changes before the select line rises, even after a complete frame has been clocked in.
- R9: When reset is released, each wiper takes the value of its shadow register. The shadow reset values are set by parameters.
- R10: After a valid command 01 or 10, busy is high for BUSY_CYCLES cycles. No other command raises it. A frame whose select fall occurs while busy is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock; a bit is captured on its rising edge |
| spi_din | input | 1 | Serial data, first bit first |
| wiper_a | output | 8 | Channel A tap code |
| wiper_b | output | 8 | Channel B tap code |
| nv_busy | output | 1 | High while a shadow update is in progress |

## Verification
The assertions check several rules on every cycle:
- The wipers change only in the RECALL and COMMIT states, and the shadows change only in COMMIT.
- Busy rises only when leaving COMMIT.
- A frame is never accepted directly from BUSY.
- The bit counter saturates.
- After RECALL, the wipers equal the shadows.

Only the bench scenarios can show the rest:
- Field positions and command semantics, decoded from real serial frames.
- Acceptance or rejection of frames by length.
- Both-channel copies.
- Shadow contents, which become visible at the ports only through a later restore command.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
    localparam int WIPER_W     = 8;
    localparam int FRAME_LONG  = 16;
    localparam int FRAME_SHORT = 8;
    localparam int CMD_POS     = 2;   // zero-based clock index of command bit 1
    localparam int ADDR_POS    = 6;   // zero-based clock index of address bit 1
    localparam int DATA_POS    = 8;   // zero-based clock index of data bit 7
    localparam int CNT_W       = $clog2(FRAME_LONG + 2);

    typedef enum logic [1:0] {
        CMD_SET_WIPER = 2'b00,
        CMD_SET_NV    = 2'b01,
        CMD_SAVE      = 2'b10,
        CMD_RESTORE   = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        S_RECALL,
        S_IDLE,
        S_SHIFT,
        S_COMMIT,
        S_BUSY
    } state_e;

    typedef struct packed {
        logic               valid;
        logic               wr_wiper;
        logic               wr_nv;
        logic               cp_w2n;
        logic               cp_n2w;
        logic               sel_a;
        logic               sel_b;
        logic [WIPER_W-1:0] data;
    } act_t;
endpackage

// File: rtl/dwc_sync.sv
module dwc_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= RESET_VAL;
                end else begin
                    if (g == 0) begin
                        stage_q[g] <= d_i;
                    end else begin
                        stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                    end
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/dwc_frame.sv
module dwc_frame
    import dwc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic               sclk_rise,
    input  logic               din,
    output logic [1:0]         cmd_o,
    output logic [1:0]         addr_o,
    output logic [WIPER_W-1:0] data_o,
    output logic [CNT_W-1:0]   cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_LONG + 1);

    logic take;
    assign take = en && sclk_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_o  <= '0;
            addr_o <= '0;
            data_o <= '0;
            cnt_o  <= '0;
        end else if (clr) begin
            cmd_o  <= '0;
            addr_o <= '0;
            data_o <= '0;
            cnt_o  <= '0;
        end else if (take) begin
            if (cnt_o == CNT_W'(CMD_POS))      cmd_o[1]  <= din;
            if (cnt_o == CNT_W'(CMD_POS + 1))  cmd_o[0]  <= din;
            if (cnt_o == CNT_W'(ADDR_POS))     addr_o[1] <= din;
            if (cnt_o == CNT_W'(ADDR_POS + 1)) addr_o[0] <= din;
            if (cnt_o >= CNT_W'(DATA_POS) && cnt_o < CNT_W'(FRAME_LONG)) begin
                data_o <= {data_o[WIPER_W-2:0], din};
            end
            if (cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
        end
    end

    // R7: the clock counter saturates one above a long frame
    a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_MAX);

    // R1: without a qualified capture or clear, the frame contents hold
    a_r1_hold_without_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !take) |=> ($stable(cnt_o) && $stable(data_o) && $stable(cmd_o) && $stable(addr_o)));
endmodule

// File: rtl/dwc_decode.sv
module dwc_decode
    import dwc_pkg::*;
(
    input  logic [1:0]         cmd_i,
    input  logic [1:0]         addr_i,
    input  logic [WIPER_W-1:0] data_i,
    input  logic [CNT_W-1:0]   cnt_i,
    output act_t               act_o
);
    logic is_long, is_short, is_copy, len_ok, addr_ok;

    always_comb begin
        is_long  = (cnt_i == CNT_W'(FRAME_LONG));
        is_short = (cnt_i == CNT_W'(FRAME_SHORT));
        is_copy  = cmd_i[1];
        len_ok   = is_long || (is_short && is_copy);
        addr_ok  = is_copy ? (addr_i != 2'b00) : (addr_i == 2'b01 || addr_i == 2'b10);

        act_o = '0;
        if (len_ok && addr_ok) begin
            act_o.valid = 1'b1;
            act_o.sel_a = addr_i[0];
            act_o.sel_b = addr_i[1];
            act_o.data  = data_i;
            unique case (cmd_e'(cmd_i))
                CMD_SET_WIPER: act_o.wr_wiper = 1'b1;
                CMD_SET_NV:    act_o.wr_nv    = 1'b1;
                CMD_SAVE:      act_o.cp_w2n   = 1'b1;
                CMD_RESTORE:   act_o.cp_n2w   = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/dual_wiper_ctrl.sv
module dual_wiper_ctrl
    import dwc_pkg::*;
#(
    parameter logic [7:0] NV_INIT_A   = 8'h80,
    parameter logic [7:0] NV_INIT_B   = 8'h80,
    parameter int         BUSY_CYCLES = 64,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_csn,
    input  logic       spi_sclk,
    input  logic       spi_din,
    output logic [7:0] wiper_a,
    output logic [7:0] wiper_b,
    output logic       nv_busy
);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    state_e              state, state_nx;
    logic [2:0]          sync_q;
    logic                csn_s, sclk_s, din_s;
    logic                csn_d, sclk_d;
    logic                cs_fall, cs_rise, sclk_rise;
    logic [1:0]          f_cmd, f_addr;
    logic [WIPER_W-1:0]  f_data;
    logic [CNT_W-1:0]    f_cnt;
    act_t                act;
    logic                nv_upd;
    logic [WIPER_W-1:0]  nv_a, nv_b;
    logic [BUSY_W-1:0]   busy_cnt;

    dwc_sync #(
        .WIDTH    (3),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_i  ({spi_csn, spi_sclk, spi_din}),
        .q_o  (sync_q)
    );

    assign csn_s  = sync_q[2];
    assign sclk_s = sync_q[1];
    assign din_s  = sync_q[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csn_d  <= 1'b1;
            sclk_d <= 1'b0;
        end else begin
            csn_d  <= csn_s;
            sclk_d <= sclk_s;
        end
    end

    assign cs_fall   = csn_d && !csn_s;
    assign cs_rise   = !csn_d && csn_s;
    assign sclk_rise = !sclk_d && sclk_s;

    dwc_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state == S_IDLE && cs_fall),
        .en       (state == S_SHIFT),
        .sclk_rise(sclk_rise),
        .din      (din_s),
        .cmd_o    (f_cmd),
        .addr_o   (f_addr),
        .data_o   (f_data),
        .cnt_o    (f_cnt)
    );

    dwc_decode u_decode (
        .cmd_i (f_cmd),
        .addr_i(f_addr),
        .data_i(f_data),
        .cnt_i (f_cnt),
        .act_o (act)
    );

    assign nv_upd = act.valid && (act.wr_nv || act.cp_w2n);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_RECALL;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_RECALL: state_nx = S_IDLE;
            S_IDLE:   if (cs_fall) state_nx = S_SHIFT;
            S_SHIFT:  if (cs_rise) state_nx = S_COMMIT;
            S_COMMIT: state_nx = nv_upd ? S_BUSY : S_IDLE;
            S_BUSY:   if (busy_cnt == '0) state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // outputs and register banks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_a  <= '0;
            wiper_b  <= '0;
            nv_a     <= NV_INIT_A;
            nv_b     <= NV_INIT_B;
            busy_cnt <= '0;
        end else begin
            unique case (state)
                S_RECALL: begin
                    wiper_a <= nv_a;
                    wiper_b <= nv_b;
                end
                S_COMMIT: begin
                    if (act.valid) begin
                        if (act.wr_wiper && act.sel_a) wiper_a <= act.data;
                        if (act.wr_wiper && act.sel_b) wiper_b <= act.data;
                        if (act.wr_nv    && act.sel_a) nv_a    <= act.data;
                        if (act.wr_nv    && act.sel_b) nv_b    <= act.data;
                        if (act.cp_w2n   && act.sel_a) nv_a    <= wiper_a;
                        if (act.cp_w2n   && act.sel_b) nv_b    <= wiper_b;
                        if (act.cp_n2w   && act.sel_a) wiper_a <= nv_a;
                        if (act.cp_n2w   && act.sel_b) wiper_b <= nv_b;
                    end
                    busy_cnt <= BUSY_W'(BUSY_CYCLES - 1);
                end
                S_BUSY: begin
                    if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign nv_busy = (state == S_BUSY);

    // R8: wipers move only on reset recall or on commit
    a_r8_wiper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(state == S_COMMIT || state == S_RECALL) |=> ($stable(wiper_a) && $stable(wiper_b)));

    // R4: shadow registers change only on commit
    a_r4_nv_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_COMMIT) |=> ($stable(nv_a) && $stable(nv_b)));

    // R9: recall leaves the wipers equal to the shadows
    a_r9_recall_copies: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RECALL) |=> (wiper_a == $past(nv_a) && wiper_b == $past(nv_b)));

    // R10: busy rises only straight out of a commit
    a_r10_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_busy) |-> ($past(state) == S_COMMIT));

    // R10: no frame is accepted directly from the busy window
    a_r10_no_shift_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BUSY) |=> (state != S_SHIFT));

    // R7: a discarded frame leaves every register untouched
    a_r7_discard_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_COMMIT && !act.valid) |=>
            ($stable(wiper_a) && $stable(wiper_b) && $stable(nv_a) && $stable(nv_b)));
endmodule

// File: tb/dual_wiper_ctrl_tb_top.sv
module dual_wiper_ctrl_tb_top;
    localparam logic [7:0] INIT_A = 8'h5A;
    localparam logic [7:0] INIT_B = 8'hC3;
    localparam int         BUSY   = 300;
    localparam int         HALF   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_csn = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_din = 1'b0;
    logic [7:0] wiper_a, wiper_b;
    logic       nv_busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] m_wa, m_wb, m_na, m_nb;

    always #5 clk = ~clk;

    dual_wiper_ctrl #(
        .NV_INIT_A  (INIT_A),
        .NV_INIT_B  (INIT_B),
        .BUSY_CYCLES(BUSY),
        .SYNC_STAGES(2)
    ) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .spi_csn (spi_csn),
        .spi_sclk(spi_sclk),
        .spi_din (spi_din),
        .wiper_a (wiper_a),
        .wiper_b (wiper_b),
        .nv_busy (nv_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send n bits of f, first bit = f[n-1]; optionally leave select low
    task automatic send(input int n, input logic [23:0] f, input bit release_cs);
        spi_csn = 1'b0;
        wait_cyc(HALF);
        for (int i = n - 1; i >= 0; i--) begin
            spi_din = f[i];
            wait_cyc(HALF);
            spi_sclk = 1'b1;
            wait_cyc(HALF);
            spi_sclk = 1'b0;
        end
        wait_cyc(HALF);
        if (release_cs) spi_csn = 1'b1;
    endtask

    function automatic logic [23:0] fr16(input logic [1:0] c, input logic [1:0] a, input logic [7:0] d);
        return {8'h00, 2'b00, c, 2'b00, a, d};
    endfunction

    function automatic logic [23:0] fr8(input logic [1:0] c, input logic [1:0] a);
        return {16'h0000, 2'b00, c, 2'b00, a};
    endfunction

    // reference model from the requirements; returns whether busy is expected
    function automatic bit model(input int n, input logic [23:0] f);
        logic [1:0] c, a;
        logic [7:0] d;
        bit ok;
        if (n == 16) begin
            c = f[13:12]; a = f[9:8]; d = f[7:0];
        end else begin
            c = f[5:4]; a = f[1:0]; d = 8'h00;
        end
        ok = (n == 16) || (n == 8 && c[1]);
        ok = ok && (c[1] ? (a != 2'b00) : (a == 2'b01 || a == 2'b10));
        if (!ok) return 1'b0;
        case (c)
            2'b00: begin if (a[0]) m_wa = d; if (a[1]) m_wb = d; end
            2'b01: begin if (a[0]) m_na = d; if (a[1]) m_nb = d; end
            2'b10: begin if (a[0]) m_na = m_wa; if (a[1]) m_nb = m_wb; end
            default: begin if (a[0]) m_wa = m_na; if (a[1]) m_wb = m_nb; end
        endcase
        return (c == 2'b01 || c == 2'b10);
    endfunction

    task automatic run(input int n, input logic [23:0] f, input string req);
        bit eb;
        send(n, f, 1'b1);
        eb = model(n, f);
        wait_cyc(8);
        chk({req, " R10 busy"}, {31'd0, nv_busy}, {31'd0, eb});
        wait_cyc(BUSY + 12);
        chk({req, " wiper_a"}, {24'd0, wiper_a}, {24'd0, m_wa});
        chk({req, " wiper_b"}, {24'd0, wiper_b}, {24'd0, m_wb});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit eb;
        void'($urandom(32'h1DC0FFEE));
        m_na = INIT_A; m_nb = INIT_B; m_wa = INIT_A; m_wb = INIT_B;
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(6);
        // R9: reset recall
        chk("R9 reset wiper_a", {24'd0, wiper_a}, {24'd0, INIT_A});
        chk("R9 reset wiper_b", {24'd0, wiper_b}, {24'd0, INIT_B});
        chk("R10 reset busy", {31'd0, nv_busy}, 32'd0);

        run(16, fr16(2'b00, 2'b01, 8'hFF), "R3 R6 write wiper A");
        run(16, fr16(2'b00, 2'b10, 8'h00), "R3 R6 write wiper B");
        run(16, fr16(2'b01, 2'b01, 8'h11), "R4 write shadow A");
        run(8,  fr8(2'b11, 2'b01), "R5 R7 restore A short");
        run(16, fr16(2'b10, 2'b11, 8'hAB), "R5 R6 save both long");
        run(16, fr16(2'b00, 2'b01, 8'h33), "R3 write wiper A");
        run(16, fr16(2'b00, 2'b10, 8'h44), "R3 write wiper B");
        run(8,  fr8(2'b11, 2'b11), "R5 R6 restore both short");
        run(8,  fr8(2'b00, 2'b01), "R7 short write discarded");
        run(16, fr16(2'b00, 2'b11, 8'h66), "R6 write addr 11 ignored");
        run(16, fr16(2'b11, 2'b00, 8'h00), "R6 addr 00 ignored");
        run(17, {7'd0, 1'b0, fr16(2'b00, 2'b01, 8'h77)}, "R7 long frame discarded");
        run(12, 24'h000FFF, "R7 odd length discarded");
        run(16, {8'hFF, 8'hCD, 8'h5E}, "R2 dont-care bits set");

        // R8: complete frame clocked in, select still low
        send(16, fr16(2'b00, 2'b01, 8'hE7), 1'b0);
        wait_cyc(20);
        chk("R8 no change before select rise", {24'd0, wiper_a}, {24'd0, m_wa});
        spi_csn = 1'b1;
        eb = model(16, fr16(2'b00, 2'b01, 8'hE7));
        wait_cyc(20);
        chk("R8 applied after select rise", {24'd0, wiper_a}, {24'd0, m_wa});

        // R10: frame starting inside the busy window is ignored
        send(16, fr16(2'b01, 2'b10, 8'h77), 1'b1);
        eb = model(16, fr16(2'b01, 2'b10, 8'h77));
        wait_cyc(8);
        chk("R10 busy after shadow write", {31'd0, nv_busy}, {31'd0, eb});
        send(16, fr16(2'b00, 2'b10, 8'h99), 1'b1);
        wait_cyc(BUSY + 12);
        chk("R10 frame during busy ignored", {24'd0, wiper_b}, {24'd0, m_wb});
        run(8, fr8(2'b11, 2'b10), "R10 R5 restore B after busy");

        // R1 R2: constrained random frames
        for (int k = 0; k < 60; k++) begin
            int n;
            int r;
            logic [23:0] f;
            r = $urandom_range(0, 9);
            if (r < 5)      n = 16;
            else if (r < 8) n = 8;
            else            n = $urandom_range(0, 20);
            f = 24'($urandom());
            run(n, f, "R1 R2 random frame");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule